// File: doc/BRIEF.md
# Barrel Shifter with Carry

This block is the operand shifter of a 32-bit load/store processor datapath. It takes one data word, a shift amount, a 3-bit code that picks the kind of shift, and the processor's current carry flag. In the same cycle it returns the shifted word and the carry the shifter produces. The block is purely combinational, so it can sit in the execute stage between register read and the ALU.

The amount follows register-specified shift rules. Only the low byte of the amount port counts. The block handles an amount of zero, amounts from one up to the word width, an amount of exactly the word width, and amounts beyond it, and it gives each shift kind its own result and carry for each of these ranges. A separate code rotates the word right by one place through the carry flag. The register file, immediate-operand decoding and flag writeback are handled elsewhere.

Top module: `barrel_shift_carry`

## Requirements
- R1: Only bits [7:0] of `op_amount` take part. Changing bits [31:8] changes neither `res_value` nor `carry_out`.
- R2: With a used amount of 0, every kind code (0 to 7) gives `res_value` = `op_value` and `carry_out` = `carry_in`.
- R3: Kind code 0 (logical left) with an amount n from 1 to 32 gives `op_value` shifted left by n with zeros filled in. The carry is input bit 32-n, so n = 32 gives a zero result and a carry equal to bit 0.
- R4: Kind code 0 with an amount above 32 gives a zero result and a zero carry.
- R5: Kind code 1 (logical right) with an amount n from 1 to 32 gives `op_value` shifted right by n with zeros filled in. The carry is input bit n-1, so n = 32 gives a zero result and a carry equal to bit 31.
- R6: Kind code 1 with an amount above 32 gives a zero result and a zero carry.
- R7: Kind code 2 (arithmetic right) with an amount n from 1 to 31 fills the vacated upper bits with input bit 31. The carry is input bit n-1.
- R8: Kind code 2 with an amount of 32 or more sets every result bit to input bit 31, and the carry equals input bit 31.
- R9: Kind code 3 (rotate right) with a non-zero amount rotates by the amount modulo 32. The carry is result bit 31, so a non-zero multiple of 32 returns the input with a carry equal to input bit 31.
- R10: Kind code 4 (rotate right one through carry) with a non-zero amount returns {`carry_in`, `op_value`[31:1]} and a carry equal to input bit 0, whatever the amount's value.
- R11: Kind codes 5, 6 and 7 return `op_value` unchanged and pass `carry_in` through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_value | input | 32 | Word to be shifted |
| op_amount | input | 32 | Shift amount; only bits [7:0] are used |
| op_kind | input | 3 | Shift kind code (0 to 4 defined, 5 to 7 pass through) |
| carry_in | input | 1 | Current carry flag |
| res_value | output | 32 | Shifted word |
| carry_out | output | 1 | Carry produced by the shifter |

## Verification
Random words are combined with amounts from three pools: the whole byte range, the band 0 to 40 around the word width, and a set of exact boundary values (0, 1, 31, 32, 33, 64, 255). With these pools, the zero, partial, exactly-full and over-range branches of each shift kind can each fail on their own. Words with bit 31 set and words with bit 31 clear are both used, so sign fill can be told apart from zero fill. Both carry values are driven, which separates carry pass-through from carry generation. Amount pairs that share a low byte but differ above it show whether the upper bits are ignored.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

    // range the used shift amount falls into, relative to the word width
    typedef enum logic [1:0] {
        AMT_ZERO = 2'd0,
        AMT_PART = 2'd1,
        AMT_FULL = 2'd2,
        AMT_OVER = 2'd3
    } amt_class_e;

    // what a right-shift stage pushes into the vacated upper bits
    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_e;

    typedef struct packed {
        amt_class_e cls;
        logic       is_nonzero;
    } amt_info_t;

    function automatic logic kind_is_defined(input logic [2:0] k);
        return (k <= 3'(SK_RRX));
    endfunction

endpackage

// File: rtl/bsc_amount_class.sv
module bsc_amount_class
    import bsc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int USED_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic [USED_W-1:0] amt,
    output amt_info_t         info,
    output logic [SEL_W-1:0]  amt_mod
);
    localparam logic [USED_W-1:0] FULL_AMT = USED_W'(DATA_W);

    always_comb begin
        info.is_nonzero = (amt != '0);
        if (amt == '0)
            info.cls = AMT_ZERO;
        else if (amt < FULL_AMT)
            info.cls = AMT_PART;
        else if (amt == FULL_AMT)
            info.cls = AMT_FULL;
        else
            info.cls = AMT_OVER;
    end

    assign amt_mod = amt[SEL_W-1:0];

endmodule

// File: rtl/bsc_right_stages.sv
module bsc_right_stages
    import bsc_pkg::*;
#(
    parameter int    DATA_W = 32,
    parameter fill_e FILL   = FILL_ZERO,
    localparam int   SEL_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stage [0:SEL_W];

    assign stage[0] = din;

    for (genvar k = 0; k < SEL_W; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [S-1:0] fill_bits;

        if (FILL == FILL_WRAP) begin : g_wrap
            assign fill_bits = stage[k][S-1:0];
        end else if (FILL == FILL_SIGN) begin : g_sign
            assign fill_bits = {S{din[DATA_W-1]}};
        end else begin : g_zero
            assign fill_bits = '0;
        end

        assign stage[k+1] = sel[k] ? {fill_bits, stage[k][DATA_W-1:S]} : stage[k];
    end

    assign dout = stage[SEL_W];

endmodule

// File: rtl/bsc_carry_pick.sv
module bsc_carry_pick
    import bsc_pkg::*;
#(
    parameter int  DATA_W = 32,
    localparam int SEL_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [2:0]        kind,
    input  amt_info_t         info,
    input  logic [SEL_W-1:0]  amt_mod,
    input  logic              cin,
    input  logic              rot_msb,
    output logic              cout
);
    logic [SEL_W-1:0] idx_left;
    logic [SEL_W-1:0] idx_right;
    logic             sign_bit;

    // modulo-width index arithmetic: amount == width maps onto bit 0 / bit top
    assign idx_left  = SEL_W'(0) - amt_mod;
    assign idx_right = amt_mod - SEL_W'(1);
    assign sign_bit  = din[DATA_W-1];

    always_comb begin
        cout = cin;
        if (info.cls != AMT_ZERO) begin
            case (kind)
                3'(SK_LSL): cout = (info.cls == AMT_OVER) ? 1'b0 : din[idx_left];
                3'(SK_LSR): cout = (info.cls == AMT_OVER) ? 1'b0 : din[idx_right];
                3'(SK_ASR): cout = (info.cls == AMT_PART) ? din[idx_right] : sign_bit;
                3'(SK_ROR): cout = rot_msb;
                3'(SK_RRX): cout = din[0];
                default:    cout = cin;
            endcase
        end
    end

endmodule

// File: rtl/barrel_shift_carry.sv
module barrel_shift_carry
    import bsc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 32,
    parameter int USED_W = 8
) (
    input  logic [DATA_W-1:0] op_value,
    input  logic [AMT_W-1:0]  op_amount,
    input  logic [2:0]        op_kind,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res_value,
    output logic              carry_out
);
    localparam int SEL_W = $clog2(DATA_W);

    logic [USED_W-1:0] amt_used;
    logic              unused_amt_hi;
    amt_info_t         info;
    logic [SEL_W-1:0]  amt_mod;

    logic [DATA_W-1:0] value_rev;
    logic [DATA_W-1:0] left_rev;
    logic [DATA_W-1:0] left_res;
    logic [DATA_W-1:0] right_log;
    logic [DATA_W-1:0] right_arith;
    logic [DATA_W-1:0] rot_res;
    logic [DATA_W-1:0] rrx_res;

    assign amt_used      = op_amount[USED_W-1:0];
    assign unused_amt_hi = ^op_amount[AMT_W-1:USED_W];

    bsc_amount_class #(.DATA_W(DATA_W), .USED_W(USED_W)) u_class (
        .amt     (amt_used),
        .info    (info),
        .amt_mod (amt_mod)
    );

    // left shift reuses the right shifter on the bit-reversed word
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign value_rev[i] = op_value[DATA_W-1-i];
        assign left_res[i]  = left_rev[DATA_W-1-i];
    end

    bsc_right_stages #(.DATA_W(DATA_W), .FILL(FILL_ZERO)) u_left (
        .din  (value_rev),
        .sel  (amt_mod),
        .dout (left_rev)
    );

    bsc_right_stages #(.DATA_W(DATA_W), .FILL(FILL_ZERO)) u_lsr (
        .din  (op_value),
        .sel  (amt_mod),
        .dout (right_log)
    );

    bsc_right_stages #(.DATA_W(DATA_W), .FILL(FILL_SIGN)) u_asr (
        .din  (op_value),
        .sel  (amt_mod),
        .dout (right_arith)
    );

    bsc_right_stages #(.DATA_W(DATA_W), .FILL(FILL_WRAP)) u_ror (
        .din  (op_value),
        .sel  (amt_mod),
        .dout (rot_res)
    );

    assign rrx_res = {carry_in, op_value[DATA_W-1:1]};

    always_comb begin
        res_value = op_value;
        if (info.is_nonzero) begin
            case (op_kind)
                3'(SK_LSL): res_value = (info.cls == AMT_PART) ? left_res : '0;
                3'(SK_LSR): res_value = (info.cls == AMT_PART) ? right_log : '0;
                3'(SK_ASR): res_value = (info.cls == AMT_PART) ? right_arith
                                                                : {DATA_W{op_value[DATA_W-1]}};
                3'(SK_ROR): res_value = rot_res;
                3'(SK_RRX): res_value = rrx_res;
                default:    res_value = op_value;
            endcase
        end
    end

    bsc_carry_pick #(.DATA_W(DATA_W)) u_carry (
        .din     (op_value),
        .kind    (op_kind),
        .info    (info),
        .amt_mod (amt_mod),
        .cin     (carry_in),
        .rot_msb (rot_res[DATA_W-1]),
        .cout    (carry_out)
    );

endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 32,
    parameter int USED_W = 8
) (
    input logic [DATA_W-1:0] op_value,
    input logic [AMT_W-1:0]  op_amount,
    input logic [2:0]        op_kind,
    input logic              carry_in,
    input logic [DATA_W-1:0] res_value,
    input logic              carry_out
);
    logic [USED_W-1:0] amt_chk;
    logic              sign_chk;
    logic              unused_chk_hi;

    assign amt_chk       = op_amount[USED_W-1:0];
    assign sign_chk      = op_value[DATA_W-1];
    assign unused_chk_hi = ^op_amount[AMT_W-1:USED_W];

    always_comb begin
        if (amt_chk == '0)
            AST_ZERO_PASS: assert (res_value == op_value && carry_out == carry_in); // R2
        if (op_kind == 3'd0 && amt_chk > USED_W'(DATA_W))
            AST_LSL_OVER_CLEAR: assert (res_value == '0 && carry_out == 1'b0); // R4
        if (op_kind == 3'd1 && amt_chk > USED_W'(DATA_W))
            AST_LSR_OVER_CLEAR: assert (res_value == '0 && carry_out == 1'b0); // R6
        if (op_kind == 3'd2 && amt_chk >= USED_W'(DATA_W))
            AST_ASR_SIGN_FILL: assert (res_value == {DATA_W{sign_chk}} && carry_out == sign_chk); // R8
        if (op_kind == 3'd3 && amt_chk != '0)
            AST_ROR_CARRY_MSB: assert (carry_out == res_value[DATA_W-1]); // R9
        if (op_kind == 3'd4 && amt_chk != '0)
            AST_RRX_ENDS: assert (res_value[DATA_W-1] == carry_in && carry_out == op_value[0]); // R10
        if (op_kind >= 3'd5)
            AST_SPARE_KIND_PASS: assert (res_value == op_value && carry_out == carry_in); // R11
    end

endmodule

bind barrel_shift_carry bsc_checker #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W),
    .USED_W (USED_W)
) u_bsc_checker (
    .op_value  (op_value),
    .op_amount (op_amount),
    .op_kind   (op_kind),
    .carry_in  (carry_in),
    .res_value (res_value),
    .carry_out (carry_out)
);

// File: tb/barrel_shift_carry_test.sv
module barrel_shift_carry_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_value  = '0;
    logic [31:0] op_amount = '0;
    logic [2:0]  op_kind   = '0;
    logic        carry_in  = 1'b0;
    logic [31:0] res_value;
    logic        carry_out;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 0;

    always #5 clk = ~clk;

    barrel_shift_carry uut (
        .op_value  (op_value),
        .op_amount (op_amount),
        .op_kind   (op_kind),
        .carry_in  (carry_in),
        .res_value (res_value),
        .carry_out (carry_out)
    );

    // reference model written from the requirements
    function automatic logic [32:0] model(input logic [31:0] v, input logic [31:0] amount,
                                          input logic [2:0] k, input logic c);
        int n;
        int m;
        logic [31:0] r;
        logic        co;
        logic [63:0] wide;
        n  = int'(amount[7:0]);
        r  = v;
        co = c;
        if (n != 0) begin
            case (k)
                3'd0: begin
                    if (n <= 32) begin
                        wide = {32'b0, v} << n;
                        r  = wide[31:0];
                        co = v[32-n];
                    end else begin
                        r = '0; co = 1'b0;
                    end
                end
                3'd1: begin
                    if (n <= 32) begin
                        wide = {v, 32'b0} >> n;
                        r  = wide[63:32];
                        co = v[n-1];
                    end else begin
                        r = '0; co = 1'b0;
                    end
                end
                3'd2: begin
                    if (n < 32) begin
                        r  = 32'($signed(v) >>> n);
                        co = v[n-1];
                    end else begin
                        r  = {32{v[31]}};
                        co = v[31];
                    end
                end
                3'd3: begin
                    m = n % 32;
                    if (m == 0) r = v;
                    else        r = (v >> m) | (v << (32 - m));
                    co = r[31];
                end
                3'd4: begin
                    r  = {c, v[31:1]};
                    co = v[0];
                end
                default: begin
                    r = v; co = c;
                end
            endcase
        end
        return {co, r};
    endfunction

    task automatic apply(input logic [31:0] v, input logic [31:0] amount,
                         input logic [2:0] k, input logic c);
        @(negedge clk);
        op_value  = v;
        op_amount = amount;
        op_kind   = k;
        carry_in  = c;
        #2;
    endtask

    task automatic check_now(input string req);
        logic [32:0] exp;
        exp = model(op_value, op_amount, op_kind, carry_in);
        tests_run++;
        if (res_value !== exp[31:0] || carry_out !== exp[32]) begin
            tests_failed++;
            $display("FAIL %s: kind=%0d amt=%0d val=%h cin=%b got res=%h c=%b expected res=%h c=%b",
                     req, op_kind, op_amount[7:0], op_value, carry_in,
                     res_value, carry_out, exp[31:0], exp[32]);
        end
    endtask

    task automatic run(input string req, input logic [31:0] v, input logic [31:0] amount,
                       input logic [2:0] k, input logic c);
        apply(v, amount, k, c);
        check_now(req);
    endtask

    function automatic string req_of(input logic [2:0] k, input int n);
        if (n == 0) return "R2";
        case (k)
            3'd0: return (n > 32) ? "R4" : "R3";
            3'd1: return (n > 32) ? "R6" : "R5";
            3'd2: return (n >= 32) ? "R8" : "R7";
            3'd3: return "R9";
            3'd4: return "R10";
            default: return "R11";
        endcase
    endfunction

    initial begin
        #100000;
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        logic [31:0] boundary [7];
        logic [31:0] r1_res;
        logic        r1_c;
        boundary = '{32'd0, 32'd1, 32'd31, 32'd32, 32'd33, 32'd64, 32'd255};
        void'($urandom(32'd1234));

        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset state: all-zero inputs give zero outputs (R2 path)
        apply('0, '0, 3'd0, 1'b0);
        tests_run++;
        if (res_value !== '0 || carry_out !== 1'b0) begin
            tests_failed++;
            $display("FAIL R2 reset: got res=%h c=%b expected res=0 c=0", res_value, carry_out);
        end

        // directed corners
        run("R2",  32'hDEAD_BEEF, 32'd0,   3'd4, 1'b1);
        run("R3",  32'h8000_0001, 32'd1,   3'd0, 1'b0);
        run("R3",  32'h0000_0001, 32'd32,  3'd0, 1'b0);
        run("R4",  32'hFFFF_FFFF, 32'd33,  3'd0, 1'b1);
        run("R5",  32'h8000_0001, 32'd1,   3'd1, 1'b0);
        run("R5",  32'h8000_0000, 32'd32,  3'd1, 1'b0);
        run("R6",  32'hFFFF_FFFF, 32'd200, 3'd1, 1'b1);
        run("R7",  32'h8000_0010, 32'd5,   3'd2, 1'b0);
        run("R8",  32'h8000_0000, 32'd32,  3'd2, 1'b0);
        run("R8",  32'h7FFF_FFFF, 32'd99,  3'd2, 1'b1);
        run("R9",  32'h8000_0001, 32'd64,  3'd3, 1'b0);
        run("R9",  32'h0000_0003, 32'd33,  3'd3, 1'b0);
        run("R10", 32'h0000_0001, 32'd7,   3'd4, 1'b1);
        run("R11", 32'h1234_5678, 32'd9,   3'd6, 1'b1);
        run("R11", 32'h1234_5678, 32'd40,  3'd7, 1'b0);

        // R1: upper amount bits must not matter
        for (int i = 0; i < 40; i++) begin
            logic [31:0] v;
            logic [7:0]  lo;
            logic [2:0]  k;
            logic        c;
            v  = $urandom;
            lo = 8'($urandom);
            k  = 3'($urandom);
            c  = 1'($urandom);
            apply(v, {24'd0, lo}, k, c);
            r1_res = res_value;
            r1_c   = carry_out;
            apply(v, {24'($urandom) | 24'd1, lo}, k, c);
            tests_run++;
            if (res_value !== r1_res || carry_out !== r1_c) begin
                tests_failed++;
                $display("FAIL R1: upper amount bits changed output got res=%h c=%b expected res=%h c=%b",
                         res_value, carry_out, r1_res, r1_c);
            end
            check_now("R1");
        end

        // constrained random over three amount pools
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] v;
            logic [31:0] amount;
            logic [2:0]  k;
            logic        c;
            int          pool;
            v    = $urandom;
            if (i % 4 == 0) v[31] = 1'b1;
            if (i % 4 == 1) v[31] = 1'b0;
            k    = 3'($urandom_range(0, 7));
            c    = 1'($urandom);
            pool = $urandom_range(0, 2);
            if (pool == 0)      amount = $urandom;
            else if (pool == 1) amount = {$urandom, 2'b0} & 32'hFFFF_FF00 | 32'($urandom_range(0, 40));
            else                amount = boundary[$urandom_range(0, 6)];
            apply(v, amount, k, c);
            check_now(req_of(k, int'(amount[7:0])));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule